// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small, fully associative cache of completed address translations for an I/O memory management unit. Every entry is keyed by a 16-bit address-space identifier (ASID) together with a 64-bit input address. It stores the translated output address, an address mask and a 2-bit permission code. A lookup port presents a key and gets back, one cycle later, a hit flag with the stored payload. A fill port, driven by a page-table walker, writes newly resolved translations. A maintenance port removes entries at three scopes: the whole cache, every entry of one ASID, or the single entry with an exact ASID and address pair.

On a fill the block writes the lowest-numbered empty entry. When every entry is occupied, it replaces the entry named by a round-robin victim pointer. A fill whose key is already present rewrites that entry in place, so a key never appears twice. When an invalidation and a fill arrive in the same cycle, the invalidation decides: if it covers the fill's key, the fill is dropped.

Top module: `asid_xlat_cache`

## Requirements
- R1: A lookup hits only when a valid entry's ASID and input address both equal the request's ASID and address; a match on one field alone is a miss.
- R2: `rsp_valid` is high exactly one cycle after `lk_valid`. On a hit, `rsp_pa`, `rsp_mask` and `rsp_perm` carry the stored values. On a miss, `rsp_hit` is 0 and those three outputs are 0.
- R3: A maintenance command with `inv_kind` = 0 empties every entry.
- R4: A command with `inv_kind` = 1 removes every entry whose ASID equals `inv_asid` and leaves all other entries intact.
- R5: A command with `inv_kind` = 2 removes only the entry whose ASID and address equal `inv_asid` and `inv_va`.
- R6: A command with `inv_kind` = 3 changes nothing.
- R7: While `rst_n` is low the cache is emptied and the victim pointer returns to entry 0.
- R8: A fill of a new key goes to the lowest-numbered empty entry. When no entry is empty, it goes to the entry named by the victim pointer. That pointer starts at 0, steps by one (wrapping after the last entry) on each such replacement, and does not move otherwise.
- R9: A fill whose ASID and address match a valid entry overwrites that entry's payload and creates no second entry.
- R10: A fill in the same cycle as an invalidation whose scope covers the fill's key is discarded. A fill whose key lies outside that scope takes effect alongside the invalidation.
- R11: A lookup is answered from the contents held before any fill or invalidation presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_asid | input | 16 | Lookup ASID |
| lk_va | input | 64 | Lookup input address |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 64 | Translated address |
| rsp_mask | output | 64 | Address mask |
| rsp_perm | output | 2 | Permission code |
| fill_valid | input | 1 | Fill strobe from the walker |
| fill_asid | input | 16 | Fill ASID |
| fill_va | input | 64 | Fill input address |
| fill_pa | input | 64 | Fill translated address |
| fill_mask | input | 64 | Fill address mask |
| fill_perm | input | 2 | Fill permission code |
| inv_valid | input | 1 | Maintenance command strobe |
| inv_kind | input | 2 | 0 all, 1 by ASID, 2 exact key, 3 none |
| inv_asid | input | 16 | Maintenance ASID |
| inv_va | input | 64 | Maintenance address (exact kind) |

## Verification
Three kinds of operation can share a cycle: a fill with an invalidation, and a lookup with either of them. The bench places a fill in the same cycle as ASID and exact invalidations that either cover or miss the fill's key. It then sweeps every key it has used, checking that covered fills are gone and uncovered ones are present. It also issues lookups in the same cycle as a fill and as an invalidation of the same key. Each response must match the contents held before that cycle, as tracked by an arithmetic model kept in the bench.

// File: rtl/xc_pkg.sv
package xc_pkg;
    typedef enum logic [1:0] {
        XC_INV_ALL   = 2'd0,
        XC_INV_ASID  = 2'd1,
        XC_INV_EXACT = 2'd2,
        XC_INV_NONE  = 2'd3
    } inv_kind_e;
endpackage

// File: rtl/xc_match.sv
module xc_match #(
    parameter int ENTRIES = 16,
    parameter int ASID_W  = 16,
    parameter int VA_W    = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0]         ent_valid,
    input  logic [ENTRIES*ASID_W-1:0]  ent_asid,
    input  logic [ENTRIES*VA_W-1:0]    ent_va,
    input  logic [ASID_W-1:0]          lk_asid,
    input  logic [VA_W-1:0]            lk_va,
    input  logic [ASID_W-1:0]          fill_asid,
    input  logic [VA_W-1:0]            fill_va,
    input  logic [ASID_W-1:0]          inv_asid,
    input  logic [VA_W-1:0]            inv_va,
    output logic [ENTRIES-1:0]         lk_hit,
    output logic [ENTRIES-1:0]         fill_hit,
    output logic [ENTRIES-1:0]         inv_asid_hit,
    output logic [ENTRIES-1:0]         inv_key_hit
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [ASID_W-1:0] a;
        logic [VA_W-1:0]   v;
        assign a = ent_asid[g*ASID_W +: ASID_W];
        assign v = ent_va[g*VA_W +: VA_W];
        assign lk_hit[g]       = ent_valid[g] && (a == lk_asid) && (v == lk_va);
        assign fill_hit[g]     = ent_valid[g] && (a == fill_asid) && (v == fill_va);
        assign inv_asid_hit[g] = ent_valid[g] && (a == inv_asid);
        assign inv_key_hit[g]  = inv_asid_hit[g] && (v == inv_va);
    end

    // R9
    lk_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit));
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               advance,
    output logic               free_any,
    output logic [IDX_W-1:0]   free_idx,
    output logic [IDX_W-1:0]   rr_idx
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        ptr_d = ptr_q;
        if (advance) begin
            ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign rr_idx = ptr_q;

    // R8
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_any |-> !advance);
endmodule

// File: rtl/asid_xlat_cache.sv
module asid_xlat_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ASID_W  = 16,
    parameter int VA_W    = 64,
    parameter int PA_W    = 64,
    parameter int PERM_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [VA_W-1:0]   rsp_mask,
    output logic [PERM_W-1:0] rsp_perm,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [VA_W-1:0]   fill_mask,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              inv_valid,
    input  logic [1:0]        inv_kind,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VA_W-1:0]   inv_va
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   pa;
        logic [VA_W-1:0]   mask;
        logic [PERM_W-1:0] perm;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic                 rsp_valid;
        logic                 rsp_hit;
        logic [PA_W-1:0]      pa;
        logic [VA_W-1:0]      mask;
        logic [PERM_W-1:0]    perm;
    } state_t;

    state_t state_d, state_q;

    logic [ENTRIES-1:0]        valid_vec;
    logic [ENTRIES*ASID_W-1:0] asid_flat;
    logic [ENTRIES*VA_W-1:0]   va_flat;
    logic [ENTRIES-1:0]        lk_hit, fill_hit, inv_asid_hit, inv_key_hit;
    logic                      free_any, rr_advance;
    logic [IDX_W-1:0]          free_idx, rr_idx;
    inv_kind_e                 kind;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign valid_vec[g]                  = state_q.ent[g].valid;
        assign asid_flat[g*ASID_W +: ASID_W] = state_q.ent[g].asid;
        assign va_flat[g*VA_W +: VA_W]       = state_q.ent[g].va;
    end

    xc_match #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .VA_W(VA_W)) match_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ent_valid    (valid_vec),
        .ent_asid     (asid_flat),
        .ent_va       (va_flat),
        .lk_asid      (lk_asid),
        .lk_va        (lk_va),
        .fill_asid    (fill_asid),
        .fill_va      (fill_va),
        .inv_asid     (inv_asid),
        .inv_va       (inv_va),
        .lk_hit       (lk_hit),
        .fill_hit     (fill_hit),
        .inv_asid_hit (inv_asid_hit),
        .inv_key_hit  (inv_key_hit)
    );

    xc_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .advance   (rr_advance),
        .free_any  (free_any),
        .free_idx  (free_idx),
        .rr_idx    (rr_idx)
    );

    assign kind = inv_kind_e'(inv_kind);

    logic             fill_block, fill_go;
    logic [IDX_W-1:0] fill_idx, dup_idx;

    always_comb begin
        // Fill is dropped when the same-cycle invalidation covers its key.
        fill_block = 1'b0;
        if (inv_valid) begin
            unique case (kind)
                XC_INV_ALL:   fill_block = 1'b1;
                XC_INV_ASID:  fill_block = (inv_asid == fill_asid);
                XC_INV_EXACT: fill_block = (inv_asid == fill_asid) && (inv_va == fill_va);
                default:      fill_block = 1'b0;
            endcase
        end
        fill_go = fill_valid && !fill_block;

        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_hit[i]) dup_idx = dup_idx | IDX_W'(i);
        end

        if (|fill_hit)    fill_idx = dup_idx;
        else if (free_any) fill_idx = free_idx;
        else               fill_idx = rr_idx;
        rr_advance = fill_go && !(|fill_hit) && !free_any;

        state_d = state_q;

        // Invalidation first.
        for (int i = 0; i < ENTRIES; i++) begin
            if (inv_valid) begin
                unique case (kind)
                    XC_INV_ALL:   state_d.ent[i].valid = 1'b0;
                    XC_INV_ASID:  if (inv_asid_hit[i]) state_d.ent[i].valid = 1'b0;
                    XC_INV_EXACT: if (inv_key_hit[i])  state_d.ent[i].valid = 1'b0;
                    default:      ;
                endcase
            end
        end

        // Then the fill, into the slot chosen from the pre-cycle contents.
        if (fill_go) begin
            state_d.ent[fill_idx].valid = 1'b1;
            state_d.ent[fill_idx].asid  = fill_asid;
            state_d.ent[fill_idx].va    = fill_va;
            state_d.ent[fill_idx].pa    = fill_pa;
            state_d.ent[fill_idx].mask  = fill_mask;
            state_d.ent[fill_idx].perm  = fill_perm;
        end

        // Lookup answers from the pre-cycle contents.
        state_d.rsp_valid = lk_valid;
        state_d.rsp_hit   = lk_valid && (|lk_hit);
        state_d.pa        = '0;
        state_d.mask      = '0;
        state_d.perm      = '0;
        if (lk_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (lk_hit[i]) begin
                    state_d.pa   = state_d.pa   | state_q.ent[i].pa;
                    state_d.mask = state_d.mask | state_q.ent[i].mask;
                    state_d.perm = state_d.perm | state_q.ent[i].perm;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_hit   = state_q.rsp_hit;
    assign rsp_pa    = state_q.pa;
    assign rsp_mask  = state_q.mask;
    assign rsp_perm  = state_q.perm;

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R2
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    // R3
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_kind == 2'd0) |=> (valid_vec == '0));
    // R8
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inv_valid) |=> ($countones(valid_vec) != 0));
endmodule

// File: tb/asid_xlat_cache_tb.sv
module asid_xlat_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int NK = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0;  logic [15:0] lk_asid = 0;  logic [63:0] lk_va = 0;
    logic rsp_valid, rsp_hit; logic [63:0] rsp_pa, rsp_mask; logic [1:0] rsp_perm;
    logic fill_valid = 0; logic [15:0] fill_asid = 0; logic [63:0] fill_va = 0;
    logic [63:0] fill_pa = 0, fill_mask = 0; logic [1:0] fill_perm = 0;
    logic inv_valid = 0; logic [1:0] inv_kind = 0; logic [15:0] inv_asid = 0;
    logic [63:0] inv_va = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asid_xlat_cache dut_i (.*);

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // Reference contents
    bit          mv [N];
    logic [15:0] ma [N];
    logic [63:0] mva [N], mpa [N], mmask [N];
    logic [1:0]  mp [N];
    int          rr = 0;
    // Expected response
    bit          e_valid, e_hit;
    logic [63:0] e_pa, e_mask; logic [1:0] e_perm;
    string       tag = "";
    // Key list for sweeps
    logic [15:0] ka [NK]; logic [63:0] kv [NK]; int nk = 0;

    function automatic void add_key(logic [15:0] a, logic [63:0] v);
        for (int i = 0; i < nk; i++) if (ka[i] == a && kv[i] == v) return;
        ka[nk] = a; kv[nk] = v; nk++;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < N; i++) mv[i] = 0;
        rr = 0;
    endfunction

    function automatic void model_step();
        int tgt; bit dup, free, blk;
        e_valid = lk_valid; e_hit = 0; e_pa = 0; e_mask = 0; e_perm = 0;
        if (lk_valid)
            for (int i = 0; i < N; i++)
                if (mv[i] && ma[i] == lk_asid && mva[i] == lk_va) begin
                    e_hit = 1; e_pa = mpa[i]; e_mask = mmask[i]; e_perm = mp[i];
                end
        dup = 0; free = 0; tgt = 0;
        for (int i = 0; i < N; i++)
            if (mv[i] && ma[i] == fill_asid && mva[i] == fill_va) begin dup = 1; tgt = i; end
        if (!dup)
            for (int i = N - 1; i >= 0; i--) if (!mv[i]) begin free = 1; tgt = i; end
        if (!dup && !free) tgt = rr;
        blk = inv_valid && (inv_kind == 0 || (inv_kind == 1 && inv_asid == fill_asid) ||
              (inv_kind == 2 && inv_asid == fill_asid && inv_va == fill_va));
        if (inv_valid)
            for (int i = 0; i < N; i++)
                if (inv_kind == 0 || (inv_kind == 1 && ma[i] == inv_asid) ||
                    (inv_kind == 2 && ma[i] == inv_asid && mva[i] == inv_va)) mv[i] = 0;
        if (fill_valid && !blk) begin
            mv[tgt] = 1; ma[tgt] = fill_asid; mva[tgt] = fill_va;
            mpa[tgt] = fill_pa; mmask[tgt] = fill_mask; mp[tgt] = fill_perm;
            if (!dup && !free) rr = (rr + 1) % N;
        end
    endfunction

    task automatic check(bit ok, string what, string act, string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", tag, what, act, exp);
        end
    endtask

    // Inputs are set just after a negedge; this advances one cycle and checks.
    task automatic go();
        model_step();
        @(negedge clk);
        if (e_valid) begin
            check(rsp_valid == 1, "rsp_valid", $sformatf("%0b", rsp_valid), "1");
            check(rsp_hit == e_hit, "hit", $sformatf("%0b", rsp_hit), $sformatf("%0b", e_hit));
            check(rsp_pa == e_pa && rsp_mask == e_mask && rsp_perm == e_perm, "data",
                  $sformatf("%h/%h/%0d", rsp_pa, rsp_mask, rsp_perm),
                  $sformatf("%h/%h/%0d", e_pa, e_mask, e_perm));
        end else begin
            check(rsp_valid == 0, "rsp_valid idle", $sformatf("%0b", rsp_valid), "0");
        end
        lk_valid = 0; fill_valid = 0; inv_valid = 0;
    endtask

    task automatic set_fill(logic [15:0] a, logic [63:0] v, logic [63:0] p);
        fill_valid = 1; fill_asid = a; fill_va = v; fill_pa = p;
        fill_mask = 64'hFFF << (v[13:12]); fill_perm = v[13:12] ^ a[1:0];
        add_key(a, v);
    endtask

    task automatic set_inv(logic [1:0] k, logic [15:0] a, logic [63:0] v);
        inv_valid = 1; inv_kind = k; inv_asid = a; inv_va = v;
    endtask

    task automatic set_lk(logic [15:0] a, logic [63:0] v);
        lk_valid = 1; lk_asid = a; lk_va = v;
    endtask

    task automatic sweep(string t);
        tag = t;
        for (int i = 0; i < nk; i++) begin set_lk(ka[i], kv[i]); go(); end
    endtask

    function automatic logic [63:0] kva(int i);
        return 64'h0000_7F00_0000_0000 | (64'(i) << 12);
    endfunction
    function automatic logic [63:0] kpa(int i);
        return 64'h0000_0080_0000_0000 ^ (64'(i) * 64'h1_3000);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R7: empty after reset; sweep keys that will be used
        for (int i = 0; i < 18; i++) add_key(16'(1 + i % 4), kva(i));
        sweep("R7 reset-empty");
        // R8: fill 16 into empty slots in order
        tag = "R8 fill";
        for (int i = 0; i < 16; i++) begin set_fill(16'(1 + i % 4), kva(i), kpa(i)); go(); end
        sweep("R1 R2 all-hit");
        // R1: one field matching is a miss
        tag = "R1 asid-only"; set_lk(16'd1, kva(1)); go();
        tag = "R1 va-only"; set_lk(16'd9, kva(0)); go();
        check(!rsp_hit, "R1 partial key", $sformatf("%0b", rsp_hit), "0");
        // R8: replacement with full cache: entry 0 then entry 1
        tag = "R8 victim";
        set_fill(16'(1 + 16 % 4), kva(16), kpa(16)); go();
        set_fill(16'(1 + 17 % 4), kva(17), kpa(17)); go();
        sweep("R8 after-evict");
        // R9: duplicate fill overwrites
        tag = "R9 dup"; set_fill(16'(1 + 5 % 4), kva(5), 64'hDEAD_0000); go();
        sweep("R9 after-dup");
        // R5: exact invalidate
        tag = "R5 exact"; set_inv(2'd2, 16'(1 + 7 % 4), kva(7)); go();
        sweep("R5 after-exact");
        // R4: by ASID
        tag = "R4 asid"; set_inv(2'd1, 16'd2, 64'h0); go();
        sweep("R4 after-asid");
        // R10: covered fill discarded; uncovered fill proceeds
        tag = "R10 covered";
        set_inv(2'd1, 16'd3, 64'h0); set_fill(16'd3, kva(30), kpa(30)); go();
        tag = "R10 exact-covered";
        set_inv(2'd2, 16'd4, kva(31)); set_fill(16'd4, kva(31), kpa(31)); go();
        tag = "R10 uncovered";
        set_inv(2'd1, 16'd1, 64'h0); set_fill(16'd4, kva(32), kpa(32)); go();
        sweep("R10 after");
        // R11: lookup sees pre-cycle contents
        tag = "R11 lk+fill"; set_lk(16'd7, kva(33)); set_fill(16'd7, kva(33), kpa(33)); go();
        tag = "R11 lk+fill-next"; set_lk(16'd7, kva(33)); go();
        tag = "R11 lk+inv"; set_lk(16'd7, kva(33)); set_inv(2'd2, 16'd7, kva(33)); go();
        tag = "R11 lk+inv-next"; set_lk(16'd7, kva(33)); go();
        // R6: kind 3 has no effect
        tag = "R6 none"; set_inv(2'd3, 16'd4, kva(32)); go();
        sweep("R6 after-none");
        // R3: flush everything
        tag = "R3 all"; set_inv(2'd0, 16'd0, 64'h0); go();
        sweep("R3 after-all");
        // R7: reset mid-run
        tag = "R7 refill";
        for (int i = 0; i < 4; i++) begin set_fill(16'd5, kva(20 + i), kpa(20 + i)); go(); end
        @(negedge clk); rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
        model_clear();
        sweep("R7 after-reset");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule